// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block tells an SDRAM command sequencer when a refresh is due. A prescaler divides the system clock. A three-bit select field chooses which divided tick drives an 8-bit interval counter. When the next count would reach the programmed compare value, the counter returns to zero and a refresh request is raised. The request stays high until the sequencer acknowledges it. Matches that occur while a request is waiting are absorbed into it and do not queue a second one.

Periodic refresh runs only when refresh is enabled, at least one bus area is mapped as SDRAM, and no standby entry is requested. In any other case the prescaler, the counter and any waiting request are cleared. A standby entry with SDRAM mapped raises a separate self-refresh request in place of the periodic one.

Top module: `sdram_refresh_timer`

## Requirements
- R1: A synchronous active-low reset sampled at a clock edge clears the refresh request, the self-refresh request and the interval count.
- R2: While refresh_en is 0 or sdram_mapped is 0, refresh_req stays 0 and the count restarts from zero once both become 1.
- R3: Select code 0 stops the count, so refresh_req never rises while it is selected.
- R4: Select codes 1 to 7 give tick divide ratios of 2, 8, 32, 128, 512, 2048 and 4096 system clocks. With compare value C from 1 to 255, refresh_req first reads 1 after exactly C times the ratio rising edges, counted from the first edge that samples the block enabled.
- R5: A compare value of 0 gives an interval of 256 ticks.
- R6: refresh_req stays 1 until refresh_ack is sampled high, and reads 0 after that edge unless a new match lands on the same edge.
- R7: A match that occurs while a request is waiting creates no extra request. After the acknowledge, refresh_req stays 0 until the next match.
- R8: Refresh intervals follow one another with no drift. The second request rises exactly two intervals after enable, whatever the timing of the acknowledge in between.
- R9: self_refresh_req equals standby_req AND sdram_mapped as sampled on the previous edge. While standby_req is 1, any waiting refresh_req is dropped and counting stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_en | input | 1 | Enables periodic auto-refresh |
| clk_sel | input | 3 | Tick select: 0 stop, 1..7 divide by 2,8,32,128,512,2048,4096 |
| cmp_value | input | 8 | Interval compare value in ticks (0 means 256) |
| sdram_mapped | input | 1 | At least one bus area is mapped as SDRAM |
| standby_req | input | 1 | Standby entry requested |
| refresh_ack | input | 1 | Sequencer has accepted the refresh request |
| refresh_req | output | 1 | Auto-refresh request, held until acknowledged |
| self_refresh_req | output | 1 | Self-refresh entry request |

## Verification
A wrong prescaler tap or a counter that is off by one shows up as a first request edge that comes early or late by whole ticks. The bench measures that edge to the exact cycle for every select code. A bad compare or wrap decision is visible within one interval, and a count phase that slips shows up when the second request is measured. A request flag that is cleared or set at the wrong time is visible one edge after an acknowledge or a standby change.

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_en,
  input  logic [2:0]       clk_sel,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic             sdram_mapped,
  input  logic             standby_req,
  input  logic             refresh_ack,
  output logic             refresh_req,
  output logic             self_refresh_req
);
  localparam int PRE_W = 12;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] tap_mask;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             active;
  logic             tick;
  logic             match;
  logic             req_q;
  logic             self_q;

  assign active  = refresh_en & sdram_mapped & ~standby_req;
  assign cnt_nxt = cnt + CNT_W'(1);

  always_comb begin
    case (clk_sel)
      3'd1:    tap_mask = PRE_W'(12'h001);
      3'd2:    tap_mask = PRE_W'(12'h007);
      3'd3:    tap_mask = PRE_W'(12'h01F);
      3'd4:    tap_mask = PRE_W'(12'h07F);
      3'd5:    tap_mask = PRE_W'(12'h1FF);
      3'd6:    tap_mask = PRE_W'(12'h7FF);
      3'd7:    tap_mask = PRE_W'(12'hFFF);
      default: tap_mask = '0;
    endcase
  end

  assign tick  = active && (clk_sel != 3'd0) && ((pre_cnt & tap_mask) == tap_mask);
  assign match = tick && (cnt_nxt == cmp_value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      req_q   <= 1'b0;
      self_q  <= 1'b0;
    end else begin
      self_q <= standby_req & sdram_mapped;
      if (!active) begin
        pre_cnt <= '0;
        cnt     <= '0;
        req_q   <= 1'b0;
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
        if (tick) cnt <= match ? '0 : cnt_nxt;
        if (match)            req_q <= 1'b1;
        else if (refresh_ack) req_q <= 1'b0;
      end
    end
  end

  assign refresh_req      = req_q;
  assign self_refresh_req = self_q;

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_en && sdram_mapped) |=> !refresh_req); // R2
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && clk_sel == 3'd0) |=> $stable(cnt)); // R3
  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack && active) |=> refresh_req); // R6
  AST_SELF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_req && sdram_mapped) |=> (self_refresh_req && !refresh_req)); // R9
endmodule

// File: tb/sdram_refresh_timer_tb.sv
module sdram_refresh_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh_en = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [7:0] cmp_value = 8'd0;
  logic       sdram_mapped = 1'b0;
  logic       standby_req = 1'b0;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic       self_refresh_req;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_refresh_timer u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .clk_sel(clk_sel),
    .cmp_value(cmp_value), .sdram_mapped(sdram_mapped), .standby_req(standby_req),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req),
    .self_refresh_req(self_refresh_req)
  );

  function automatic int ratio(input int code);
    if (code == 0) return 0;
    if (code == 7) return 4096;
    return 2 << (2 * (code - 1));
  endfunction

  function automatic int interval(input int code, input int cmp);
    return ratio(code) * ((cmp == 0) ? 256 : cmp);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input int code, input int cmp, input string req);
    int n;
    int exp;
    exp = interval(code, cmp);
    refresh_en = 1'b0;
    edges(1);
    clk_sel = 3'(code); cmp_value = 8'(cmp); sdram_mapped = 1'b1; refresh_en = 1'b1;
    n = 0;
    while (!refresh_req && n < 300000) begin edges(1); n++; end
    check(req, n, exp);
    refresh_ack = 1'b1;
    edges(1); n++;
    refresh_ack = 1'b0;
    if (exp > 1) check("R6", refresh_req, 0);
    while (!refresh_req && n < 600000) begin edges(1); n++; end
    check("R8", n, 2 * exp);
    refresh_ack = 1'b1; edges(1); refresh_ack = 1'b0;
  endtask

  initial begin
    int lim;
    void'($urandom(32'd1234));
    edges(2);
    check("R1", refresh_req, 0);
    check("R1", self_refresh_req, 0);
    rst_n = 1'b1;

    refresh_en = 1'b1; clk_sel = 3'd1; cmp_value = 8'd2; sdram_mapped = 1'b0;
    edges(40);
    check("R2", refresh_req, 0);
    sdram_mapped = 1'b1; refresh_en = 1'b0;
    edges(40);
    check("R2", refresh_req, 0);

    refresh_en = 1'b1; clk_sel = 3'd0; cmp_value = 8'd1;
    edges(300);
    check("R3", refresh_req, 0);

    for (int c = 1; c <= 7; c++) measure(c, (c > 5) ? 1 : 3, "R4");
    measure(1, 0, "R5");
    measure(1, 1, "R4");
    measure(1, 255, "R4");

    for (int t = 0; t < 10; t++) begin
      int code;
      int cmp;
      code = 1 + int'($urandom % 7);
      lim = 4096 / ratio(code);
      cmp = 1 + int'($urandom % lim);
      if (cmp > 255) cmp = 255;
      measure(code, cmp, "R4");
    end

    refresh_en = 1'b0; edges(1);
    clk_sel = 3'd1; cmp_value = 8'd2; refresh_en = 1'b1;
    edges(4);
    check("R7", refresh_req, 1);
    edges(5);
    refresh_ack = 1'b1; edges(1); refresh_ack = 1'b0;
    check("R7", refresh_req, 0);
    edges(1);
    check("R7", refresh_req, 0);
    edges(1);
    check("R7", refresh_req, 1);

    standby_req = 1'b1;
    edges(1);
    check("R9", self_refresh_req, 1);
    check("R9", refresh_req, 0);
    edges(30);
    check("R9", refresh_req, 0);
    sdram_mapped = 1'b0;
    edges(1);
    check("R9", self_refresh_req, 0);
    sdram_mapped = 1'b1; standby_req = 1'b0;
    edges(1);
    check("R9", self_refresh_req, 0);

    edges(4);
    check("R1", refresh_req, 1);
    standby_req = 1'b1; edges(1); standby_req = 1'b0;
    rst_n = 1'b0;
    edges(1);
    check("R1", refresh_req, 0);
    check("R1", self_refresh_req, 0);
    rst_n = 1'b1;
    edges(3);
    check("R1", refresh_req, 0);
    edges(1);
    check("R1", refresh_req, 1);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule